// File: doc/BRIEF.md
# Vector Memory Address Generator

This block turns one vector memory command into the per-element stream of byte addresses that a banked memory needs. A command holds a base address, an addressing mode, an element width, a vector length and, for strided work, a signed stride. In indexed mode a separate stream supplies one offset per element. Every generated element is checked against its own width. A well-aligned element goes into a decoupling queue. A misaligned element is reported on an error strobe and dropped.

The queue sits between generation and the memory side. A long run of indexed accesses can therefore pile up while the consumer is slow, and the issue side stays free. Each queued element leaves with its address, the memory bank it targets, the byte lane inside that bank's 32-byte word, its element number and its width code.

The sequencer has four states:
- S_IDLE waits for a command. Its transitions are *accept-strided* to S_STEP, *accept-indexed* to S_INDEX, and *accept-empty* to S_FINISH when the length is zero.
- S_STEP generates unit or constant-stride elements. Its transition is *last-element* to S_FINISH.
- S_INDEX generates indexed elements. Its transition is also *last-element* to S_FINISH.
- S_FINISH raises the completion pulse. Its transition is *release* back to S_IDLE.

Top module: `vec_agen`

## Requirements
- R1: While reset is held low and in the cycle after it is released, cmd_ready is 1 and out_valid, idx_ready, err_valid and done are all 0.
- R2: Width code w (0, 1, 2, 3) selects elements of 1, 2, 4 or 8 bytes. In mode code 0 (unit stride) element i is at base + i*(1<<w), taken modulo 2^32. Mode code 3 behaves exactly like code 0.
- R3: In mode code 1 (constant stride) element i is at base + i*stride. The stride is a 32-bit two's-complement value and the sum is taken modulo 2^32.
- R4: In mode code 2 (indexed) element i is at base + idx_data. Exactly one index is consumed per element, in element order, on a cycle with idx_valid and idx_ready both high. idx_ready is high only while indexed generation runs and the queue has room.
- R5: Queued elements leave in generation order. Each carries its element number (out_elem, counting from 0) and the command's width code (out_width).
- R6: out_bank equals address bits [7:5] and out_lane equals address bits [4:0]. These come from eight banks, each with a 32-byte word.
- R7: An element whose address is not a multiple of its size is not queued. Instead err_valid is high for exactly one cycle, the cycle after that element is generated. err_elem and err_addr give its element number and address.
- R8: The queue holds QDEPTH elements (128 by default). While it is full, generation pauses and idx_ready is low. No element is lost or repeated.
- R9: While out_valid is high and out_ready is low, out_valid, out_addr and out_elem hold their values.
- R10: A command is taken only on a cycle with cmd_valid and cmd_ready both high. cmd_ready stays low until done has pulsed for one cycle. done comes one cycle after the last element is generated, or one cycle after acceptance when the length is 0, and a length of 0 produces no elements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Generator idle, command may be taken |
| cmd_mode | input | 2 | 0 unit, 1 strided, 2 indexed, 3 unit |
| cmd_width | input | 2 | Element width code: 1, 2, 4 or 8 bytes |
| cmd_base | input | ADDR_W | Base byte address |
| cmd_stride | input | ADDR_W | Signed byte stride (strided mode) |
| cmd_vlen | input | VL_W | Number of elements |
| idx_valid | input | 1 | Index offered |
| idx_ready | output | 1 | Index consumed this cycle if valid |
| idx_data | input | ADDR_W | Byte offset for the current element |
| out_valid | output | 1 | Queued element available |
| out_ready | input | 1 | Consumer takes the element |
| out_addr | output | ADDR_W | Element byte address |
| out_bank | output | BANK_W | Target bank |
| out_lane | output | OFF_W | Byte lane within the bank word |
| out_elem | output | VL_W | Element number |
| out_width | output | 2 | Element width code |
| err_valid | output | 1 | Misaligned element dropped |
| err_elem | output | VL_W | Number of the dropped element |
| err_addr | output | ADDR_W | Address of the dropped element |
| done | output | 1 | Command generation complete |

## Verification
The bench focuses on the alignment boundary. It uses a stride of 6 with 4-byte elements, so aligned and misaligned elements alternate, and odd indices with 2-byte elements. A design that masked the wrong number of low bits would queue bad elements, and a design that skipped the error path would shift every following element number.

A base just below 2^32 and a negative stride exercise address wraparound. A broken adder would show up as wrong banks and lanes.

The queue is filled to its limit with the consumer held off and a third, indexed command waiting behind it. A design that overwrote a full queue, or kept consuming indices while full, would lose or repeat elements once the consumer resumes. Random backpressure exposes outputs that change while stalled. A zero-length command checks that completion still arrives and that no element leaks out.

// File: rtl/vec_agen_pkg.sv
package vec_agen_pkg;

    localparam logic [1:0] MODE_UNIT   = 2'd0;
    localparam logic [1:0] MODE_STRIDE = 2'd1;
    localparam logic [1:0] MODE_INDEX  = 2'd2;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_STEP   = 2'd1,
        S_INDEX  = 2'd2,
        S_FINISH = 2'd3
    } gen_state_e;

    // Byte size of an element for a width code.
    function automatic logic [3:0] width_bytes(input logic [1:0] w);
        return 4'd1 << w;
    endfunction

    // True when the three low address bits suit the element width.
    function automatic logic is_aligned(input logic [2:0] low, input logic [1:0] w);
        logic [2:0] mask;
        mask = 3'(width_bytes(w) - 4'd1);
        return (low & mask) == 3'd0;
    endfunction

endpackage

// File: rtl/vec_agen_seq.sv
module vec_agen_seq
    import vec_agen_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int VL_W   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_mode,
    input  logic [1:0]        cmd_width,
    input  logic [ADDR_W-1:0] cmd_base,
    input  logic [ADDR_W-1:0] cmd_stride,
    input  logic [VL_W-1:0]   cmd_vlen,
    input  logic              idx_valid,
    output logic              idx_ready,
    input  logic [ADDR_W-1:0] idx_data,
    input  logic              q_full,
    output logic              push,
    output logic [ADDR_W-1:0] push_addr,
    output logic [VL_W-1:0]   push_elem,
    output logic [1:0]        push_width,
    output logic              err_valid,
    output logic [VL_W-1:0]   err_elem,
    output logic [ADDR_W-1:0] err_addr,
    output logic              done
);

    gen_state_e        state, state_nx;
    logic [1:0]        width_q;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] stride_q;
    logic [ADDR_W-1:0] cur_q;
    logic [VL_W-1:0]   vlen_q;
    logic [VL_W-1:0]   cnt_q;

    logic              step;
    logic              last;
    logic              elem_ok;
    logic              accept;
    logic [ADDR_W-1:0] elem_addr;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Next state and combinational outputs.
    always_comb begin
        accept    = (state == S_IDLE) && cmd_valid;
        cmd_ready = (state == S_IDLE);
        idx_ready = (state == S_INDEX) && !q_full;
        done      = (state == S_FINISH);
        unique case (state)
            S_STEP:  step = !q_full;
            S_INDEX: step = !q_full && idx_valid;
            default: step = 1'b0;
        endcase
        elem_addr  = (state == S_INDEX) ? base_q + idx_data : cur_q;
        elem_ok    = is_aligned(elem_addr[2:0], width_q);
        last       = (cnt_q == vlen_q - VL_W'(1));
        push       = step && elem_ok;
        push_addr  = elem_addr;
        push_elem  = cnt_q;
        push_width = width_q;

        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (cmd_valid) begin
                    if (cmd_vlen == '0)              state_nx = S_FINISH;
                    else if (cmd_mode == MODE_INDEX) state_nx = S_INDEX;
                    else                             state_nx = S_STEP;
                end
            end
            S_STEP, S_INDEX: begin
                if (step && last) state_nx = S_FINISH;
            end
            S_FINISH: state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    // Datapath and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            width_q   <= '0;
            base_q    <= '0;
            stride_q  <= '0;
            cur_q     <= '0;
            vlen_q    <= '0;
            cnt_q     <= '0;
            err_valid <= 1'b0;
            err_elem  <= '0;
            err_addr  <= '0;
        end else begin
            err_valid <= step && !elem_ok;
            if (step) begin
                err_elem <= cnt_q;
                err_addr <= elem_addr;
            end
            if (accept) begin
                width_q  <= cmd_width;
                base_q   <= cmd_base;
                cur_q    <= cmd_base;
                vlen_q   <= cmd_vlen;
                cnt_q    <= '0;
                stride_q <= (cmd_mode == MODE_STRIDE) ? cmd_stride
                                                      : ADDR_W'(width_bytes(cmd_width));
            end else if (step) begin
                cur_q <= cur_q + stride_q;
                cnt_q <= cnt_q + VL_W'(1);
            end
        end
    end

endmodule

// File: rtl/vec_agen_fifo.sv
module vec_agen_fifo #(
    parameter int W     = 41,
    parameter int DEPTH = 128
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    output logic         full,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             wr_en, rd_en;

    always_comb begin
        full      = (count == CNT_W'(DEPTH));
        out_valid = (count != '0);
        wr_en     = push && !full;
        rd_en     = out_valid && out_ready;
        out_data  = mem[rd_ptr];
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_en) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
            if (rd_en) rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
            unique case ({wr_en, rd_en})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/vec_agen_map.sv
module vec_agen_map #(
    parameter int ADDR_W     = 32,
    parameter int WORD_BYTES = 32,
    parameter int NBANK      = 8,
    localparam int OFF_W     = $clog2(WORD_BYTES),
    localparam int BANK_W    = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [BANK_W-1:0] bank,
    output logic [OFF_W-1:0]  lane
);

    assign lane = addr[OFF_W-1:0];

    generate
        if (NBANK > 1) begin : g_multi
            assign bank = addr[OFF_W +: BANK_W];
        end else begin : g_single
            assign bank = '0;
        end
    endgenerate

endmodule

// File: rtl/vec_agen.sv
module vec_agen
    import vec_agen_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int MAX_VL     = 64,
    parameter int QDEPTH     = 128,
    parameter int NBANK      = 8,
    parameter int WORD_BYTES = 32,
    localparam int VL_W      = $clog2(MAX_VL + 1),
    localparam int OFF_W     = $clog2(WORD_BYTES),
    localparam int BANK_W    = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_mode,
    input  logic [1:0]        cmd_width,
    input  logic [ADDR_W-1:0] cmd_base,
    input  logic [ADDR_W-1:0] cmd_stride,
    input  logic [VL_W-1:0]   cmd_vlen,
    input  logic              idx_valid,
    output logic              idx_ready,
    input  logic [ADDR_W-1:0] idx_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_addr,
    output logic [BANK_W-1:0] out_bank,
    output logic [OFF_W-1:0]  out_lane,
    output logic [VL_W-1:0]   out_elem,
    output logic [1:0]        out_width,
    output logic              err_valid,
    output logic [VL_W-1:0]   err_elem,
    output logic [ADDR_W-1:0] err_addr,
    output logic              done
);

    localparam int ENT_W = 2 + VL_W + ADDR_W;

    logic              q_full;
    logic              push;
    logic [ADDR_W-1:0] push_addr;
    logic [VL_W-1:0]   push_elem;
    logic [1:0]        push_width;
    logic [ENT_W-1:0]  q_out;

    vec_agen_seq #(.ADDR_W(ADDR_W), .VL_W(VL_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_ready  (cmd_ready),
        .cmd_mode   (cmd_mode),
        .cmd_width  (cmd_width),
        .cmd_base   (cmd_base),
        .cmd_stride (cmd_stride),
        .cmd_vlen   (cmd_vlen),
        .idx_valid  (idx_valid),
        .idx_ready  (idx_ready),
        .idx_data   (idx_data),
        .q_full     (q_full),
        .push       (push),
        .push_addr  (push_addr),
        .push_elem  (push_elem),
        .push_width (push_width),
        .err_valid  (err_valid),
        .err_elem   (err_elem),
        .err_addr   (err_addr),
        .done       (done)
    );

    vec_agen_fifo #(.W(ENT_W), .DEPTH(QDEPTH)) u_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data ({push_width, push_elem, push_addr}),
        .full      (q_full),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (q_out)
    );

    assign out_addr  = q_out[ADDR_W-1:0];
    assign out_elem  = q_out[ADDR_W +: VL_W];
    assign out_width = q_out[ADDR_W + VL_W +: 2];

    vec_agen_map #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES), .NBANK(NBANK)) u_map (
        .addr (out_addr),
        .bank (out_bank),
        .lane (out_lane)
    );

endmodule

// File: rtl/vec_agen_chk.sv
module vec_agen_chk #(
    parameter int ADDR_W = 32,
    parameter int VL_W   = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic              idx_ready,
    input logic              q_full,
    input logic              out_valid,
    input logic              out_ready,
    input logic [ADDR_W-1:0] out_addr,
    input logic [VL_W-1:0]   out_elem,
    input logic [1:0]        out_width,
    input logic              done
);

    // R9: a stalled output stays put
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_elem));

    // R7: only aligned elements reach the output
    p_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_addr & ((ADDR_W'(1) << out_width) - ADDR_W'(1))) == '0);

    // R8: no index is taken while the queue is full
    p_room_r8: assert property (@(posedge clk) disable iff (!rst_n)
        idx_ready |-> !q_full);

    // R10: an accepted command makes the generator busy
    p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready |=> !cmd_ready);

    // R10: completion returns the generator to idle
    p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> cmd_ready && !done);

endmodule

bind vec_agen vec_agen_chk #(.ADDR_W(ADDR_W), .VL_W(VL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .idx_ready (idx_ready),
    .q_full    (q_full),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_addr  (out_addr),
    .out_elem  (out_elem),
    .out_width (out_width),
    .done      (done)
);

// File: tb/sim_vec_agen.sv
module sim_vec_agen;

    localparam int AW  = 32;
    localparam int VLW = 7;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           cmd_valid, cmd_ready;
    logic [1:0]     cmd_mode, cmd_width;
    logic [AW-1:0]  cmd_base, cmd_stride;
    logic [VLW-1:0] cmd_vlen;
    logic           idx_valid, idx_ready;
    logic [AW-1:0]  idx_data;
    logic           out_valid, out_ready;
    logic [AW-1:0]  out_addr;
    logic [2:0]     out_bank;
    logic [4:0]     out_lane;
    logic [VLW-1:0] out_elem;
    logic [1:0]     out_width;
    logic           err_valid;
    logic [VLW-1:0] err_elem;
    logic [AW-1:0]  err_addr;
    logic           done;

    always #5 clk = ~clk;

    vec_agen u0 (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_mode(cmd_mode),
        .cmd_width(cmd_width), .cmd_base(cmd_base), .cmd_stride(cmd_stride),
        .cmd_vlen(cmd_vlen),
        .idx_valid(idx_valid), .idx_ready(idx_ready), .idx_data(idx_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
        .out_bank(out_bank), .out_lane(out_lane), .out_elem(out_elem),
        .out_width(out_width),
        .err_valid(err_valid), .err_elem(err_elem), .err_addr(err_addr),
        .done(done)
    );

    int checks = 0;
    int errors = 0;
    int rdy_mode = 0;
    int done_cnt = 0;
    int cmd_cnt = 0;
    bit pend = 0;
    bit hold_prev = 0;
    logic [AW-1:0] hold_addr;
    logic [15:0]   lf = 16'hACE1;

    logic [AW-1:0] ea[$];
    int            ee[$];
    int            ew[$];
    string         er[$];
    logic [AW-1:0] xa[$];
    int            xe[$];
    logic [AW-1:0] feed[$];
    logic [AW-1:0] idx_src [64];

    logic [AW-1:0] m_a;
    int            m_e, m_w;
    string         m_r;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Consumer ready and index feeder, driven at the falling edge.
    initial begin
        out_ready = 1'b0;
        idx_valid = 1'b0;
        idx_data  = '0;
        forever begin
            @(negedge clk);
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            out_ready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? lf[0] : 1'b0;
            if (pend) void'(feed.pop_front());
            if (feed.size() > 0) begin
                idx_valid = 1'b1;
                idx_data  = feed[0];
            end else begin
                idx_valid = 1'b0;
            end
            #1 pend = idx_valid && idx_ready;
        end
    end

    // Reference comparison every cycle.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (rst_n) begin
                if (hold_prev)
                    chk(out_valid && out_addr == hold_addr, "R9", "stalled output moved",
                        out_addr, hold_addr);
                hold_prev = out_valid && !out_ready;
                hold_addr = out_addr;
                if (out_valid && out_ready) begin
                    if (ea.size() == 0) begin
                        chk(1'b0, "R5", "unexpected output", out_addr, '0);
                    end else begin
                        m_a = ea.pop_front(); m_e = ee.pop_front();
                        m_w = ew.pop_front(); m_r = er.pop_front();
                        chk(out_addr == m_a, m_r, "address", out_addr, m_a);
                        chk(int'(out_elem) == m_e, "R5", "element number", AW'(out_elem), AW'(m_e));
                        chk(int'(out_width) == m_w, "R5", "width code", AW'(out_width), AW'(m_w));
                        chk(out_bank == m_a[7:5], "R6", "bank", AW'(out_bank), AW'(m_a[7:5]));
                        chk(out_lane == m_a[4:0], "R6", "lane", AW'(out_lane), AW'(m_a[4:0]));
                    end
                end
                if (err_valid) begin
                    if (xa.size() == 0) begin
                        chk(1'b0, "R7", "unexpected misalign report", err_addr, '0);
                    end else begin
                        m_a = xa.pop_front(); m_e = xe.pop_front();
                        chk(err_addr == m_a, "R7", "misalign address", err_addr, m_a);
                        chk(int'(err_elem) == m_e, "R7", "misalign element", AW'(err_elem), AW'(m_e));
                    end
                end
                if (done) done_cnt++;
            end
        end
    end

    task automatic run_cmd(input logic [1:0] m, input logic [1:0] w,
                           input logic [AW-1:0] base, input logic [AW-1:0] stride,
                           input int vl, input bit wait_end);
        logic [AW-1:0] stp, a;
        string r;
        stp = (m == 2'd1) ? stride : (32'd1 << w);
        r   = (m == 2'd2) ? "R4" : (m == 2'd1) ? "R3" : "R2";
        for (int i = 0; i < vl; i++) begin
            if (m == 2'd2) begin
                a = base + idx_src[i];
                feed.push_back(idx_src[i]);
            end else begin
                a = base + stp * 32'(i);
            end
            if ((a & ((32'd1 << w) - 32'd1)) == 32'd0) begin
                ea.push_back(a); ee.push_back(i); ew.push_back(int'(w)); er.push_back(r);
            end else begin
                xa.push_back(a); xe.push_back(i);
            end
        end
        @(negedge clk);
        cmd_valid = 1'b1; cmd_mode = m; cmd_width = w;
        cmd_base = base; cmd_stride = stride; cmd_vlen = VLW'(vl);
        #1;
        while (!cmd_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_cnt++;
        if (wait_end) while (done_cnt < cmd_cnt) @(negedge clk);
    endtask

    task automatic drain();
        while (ea.size() > 0 || xa.size() > 0 || done_cnt < cmd_cnt) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_mode = '0; cmd_width = '0;
        cmd_base = '0; cmd_stride = '0; cmd_vlen = '0;
        repeat (3) @(negedge clk);
        #3;
        // R1 reset state
        chk(cmd_ready == 1'b1, "R1", "cmd_ready in reset", AW'(cmd_ready), 1);
        chk(out_valid == 1'b0, "R1", "out_valid in reset", AW'(out_valid), 0);
        chk(idx_ready == 1'b0, "R1", "idx_ready in reset", AW'(idx_ready), 0);
        chk(err_valid == 1'b0, "R1", "err_valid in reset", AW'(err_valid), 0);
        chk(done == 1'b0, "R1", "done in reset", AW'(done), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #3;
        chk(cmd_ready == 1'b1 && !out_valid && !done, "R1", "idle after reset",
            AW'({cmd_ready, out_valid, done}), AW'(3'b100));

        // R2 unit stride, 4-byte elements
        run_cmd(2'd0, 2'd2, 32'h0000_1000, 32'd0, 20, 1'b1);
        drain();
        // R2 / R7 unit stride with a misaligned base for 2-byte elements
        run_cmd(2'd0, 2'd1, 32'h0000_1001, 32'd0, 8, 1'b1);
        drain();
        // R2 mode code 3 behaves as unit stride, with wraparound past 2^32
        run_cmd(2'd3, 2'd0, 32'hFFFF_FFF0, 32'd0, 40, 1'b1);
        drain();
        // R3 negative stride, 8-byte elements
        run_cmd(2'd1, 2'd3, 32'h0000_2000, 32'hFFFF_FFE8, 30, 1'b1);
        drain();
        // R3 / R7 stride of 6 with 4-byte elements: every other one misaligned
        run_cmd(2'd1, 2'd2, 32'h0000_0100, 32'd6, 16, 1'b1);
        drain();
        // R4 / R7 indexed, 2-byte elements with mixed offsets
        for (int i = 0; i < 64; i++) idx_src[i] = 32'(i * 37);
        idx_src[5] = 32'hFFFF_F000;
        run_cmd(2'd2, 2'd1, 32'h0000_3000, 32'd0, 24, 1'b1);
        drain();
        // R10 zero-length command
        run_cmd(2'd0, 2'd2, 32'h0000_0040, 32'd0, 0, 1'b1);
        drain();
        chk(cmd_ready == 1'b1, "R10", "ready after empty command", AW'(cmd_ready), 1);
        chk(ea.size() == 0 && xa.size() == 0, "R10", "empty command produced nothing",
            AW'(ea.size() + xa.size()), 0);

        // R9 random backpressure
        rdy_mode = 1;
        run_cmd(2'd0, 2'd0, 32'h0000_5003, 32'd0, 64, 1'b1);
        run_cmd(2'd1, 2'd3, 32'h0000_6000, 32'd72, 50, 1'b1);
        drain();

        // R8 fill the queue and hold a third command behind it
        rdy_mode = 2;
        run_cmd(2'd1, 2'd3, 32'h0000_4000, 32'd8, 64, 1'b1);
        run_cmd(2'd1, 2'd3, 32'h0000_8000, 32'hFFFF_FFF8, 64, 1'b1);
        for (int i = 0; i < 64; i++) idx_src[i] = 32'(i * 4);
        run_cmd(2'd2, 2'd2, 32'h0000_9000, 32'd0, 64, 1'b0);
        repeat (10) @(negedge clk);
        #3;
        chk(idx_ready == 1'b0, "R8", "index taken while queue full", AW'(idx_ready), 0);
        chk(cmd_ready == 1'b0, "R10", "busy while stalled", AW'(cmd_ready), 0);
        chk(done_cnt == cmd_cnt - 1, "R8", "stalled command completed early",
            AW'(done_cnt), AW'(cmd_cnt - 1));
        chk(out_valid == 1'b1, "R8", "queue holds data", AW'(out_valid), 1);
        rdy_mode = 0;
        drain();

        chk(ea.size() == 0, "R5", "elements left undelivered", AW'(ea.size()), 0);
        chk(xa.size() == 0, "R7", "misalign reports missing", AW'(xa.size()), 0);
        chk(done_cnt == cmd_cnt, "R10", "done pulse count", AW'(done_cnt), AW'(cmd_cnt));
        chk(feed.size() == 0, "R4", "indices left unconsumed", AW'(feed.size()), 0);
        summary();
        $finish;
    end

endmodule